// File: doc/BRIEF.md
# Completion-Queue Pin Interrupt Aggregator

This block drives one level-sensitive interrupt pin for a set of completion queues inside a storage controller. Each queue has a tail pointer that the device advances when it posts a completion entry and a head pointer that the host writes through a doorbell. A queue holds unacknowledged entries whenever its head and tail differ. The block keeps a tally of the interrupt-enabled queues in that state. It lets the pin go only when that tally has dropped to zero, so acknowledging one queue cannot silence the pin while another queue still waits.

Queues are created with a size, a vector number and an interrupt-enable flag, and are later deleted. A 32-bit status bitmap, indexed by vector, records which vectors have raised the pin. A host-written mask hides chosen vectors from the pin. Polled queues, created with interrupts disabled, may hold entries without touching the tally, the status bitmap or the pin.

Top module: `cq_pin_irq_agg`

## Requirements
- R1: After reset every queue is absent, the pending tally `pend_cnt` is 0, `irq_status` is 0, the mask is 0 and `irq_pin` is low.
- R2: `pend_cnt` equals the number of created, interrupt-enabled queues whose head differs from their tail. It rises by one only when a post takes such a queue from empty to non-empty. Further posts to a non-empty queue leave it unchanged.
- R3: A doorbell that sets a non-empty queue's head equal to its tail lowers `pend_cnt` by one. A doorbell is ignored when the queue is already empty, when the queue is not created, or when the written head is not below the queue size.
- R4: Deleting a created queue that holds entries lowers `pend_cnt` by one. The queue is then absent, and later posts to it are ignored.
- R5: A post that leaves an interrupt-enabled queue non-empty sets `irq_status` bit number equal to that queue's vector. When a drain (R3) or a delete (R4) leaves `pend_cnt` at 0, all of `irq_status` clears. While `pend_cnt` is above 0, status bits stay set.
- R6: A queue created with interrupts disabled never changes `pend_cnt` or `irq_status`. Entries left in it do not hold `irq_pin` high.
- R7: `irq_pin` is a register. After each clock edge it holds the OR of the `irq_status` bits not set in the mask, taken as they stood after the previous edge. A mask write takes the value of `mask_wdata` when `mask_we` is high.
- R8: Pointers run from 0 to size-1 and wrap to 0. A post is ignored when it would make the tail equal to the head, which means the queue is full.
- R9: When a post and a doorbell hit the same queue in one cycle, the full check and the doorbell's empty check use the pointers from before that cycle. The change in `pend_cnt` is judged from the final pointer values, and is at most one per queue.
- R10: A create takes effect only on a queue that is not created and only with a size of at least 2. It starts the queue with both pointers at 0. Otherwise it is ignored, and an existing queue keeps its size, vector and pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_valid | input | 1 | Create request |
| cr_qid | input | 3 | Queue to create |
| cr_size | input | 16 | Entries in the new queue |
| cr_vec | input | 5 | Vector number for the new queue |
| cr_ien | input | 1 | Interrupt enable for the new queue |
| del_valid | input | 1 | Delete request |
| del_qid | input | 3 | Queue to delete |
| post_valid | input | 1 | Device posts one completion entry |
| post_qid | input | 3 | Queue receiving the entry |
| db_valid | input | 1 | Head doorbell write |
| db_qid | input | 3 | Queue whose head is written |
| db_head | input | 16 | New head value |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 32 | New mask value, 1 hides a vector |
| irq_pin | output | 1 | Level interrupt pin |
| irq_status | output | 32 | Per-vector interrupt status |
| pend_cnt | output | 4 | Interrupt-enabled queues holding entries |

## Verification
The checks assume that the host never acknowledges entries that have not been posted. Every doorbell head therefore lies between the old head and the tail, inside the occupied part of the ring; the block checks only that the value is below the size. They also assume that each port names at most one queue per cycle. The stimulus keeps to both assumptions: it writes heads only up to positions that have already been posted, and it drives one request per port in each cycle. Same-cycle post and doorbell pairs are aimed deliberately at a single queue.

// File: rtl/cq_pin_irq_agg.sv
module cq_pin_irq_agg #(
  parameter int NQ   = 8,
  parameter int PW   = 16,
  parameter int NVEC = 32,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int VW  = $clog2(NVEC),
  localparam int CW  = $clog2(NQ + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cr_valid,
  input  logic [QW-1:0]   cr_qid,
  input  logic [PW-1:0]   cr_size,
  input  logic [VW-1:0]   cr_vec,
  input  logic            cr_ien,
  input  logic            del_valid,
  input  logic [QW-1:0]   del_qid,
  input  logic            post_valid,
  input  logic [QW-1:0]   post_qid,
  input  logic            db_valid,
  input  logic [QW-1:0]   db_qid,
  input  logic [PW-1:0]   db_head,
  input  logic            mask_we,
  input  logic [NVEC-1:0] mask_wdata,
  output logic            irq_pin,
  output logic [NVEC-1:0] irq_status,
  output logic [CW-1:0]   pend_cnt
);

  logic [NQ-1:0]   q_on, q_ien;
  logic [VW-1:0]   q_vec  [NQ];
  logic [PW-1:0]   q_size [NQ];
  logic [PW-1:0]   q_head [NQ];
  logic [PW-1:0]   q_tail [NQ];

  logic [PW-1:0]   t_inc [NQ];
  logic [PW-1:0]   h_n   [NQ];
  logic [PW-1:0]   t_n   [NQ];
  logic [NQ-1:0]   cr_hit, del_hit, post_ok, db_ok, was_ne, now_ne, inc, dec;

  logic [NVEC-1:0] set_bits, status_n, mask_q;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            drain_req;

  assign pend_cnt = cnt_q;

  always_comb begin
    set_bits = '0;
    cnt_n    = cnt_q;
    for (int i = 0; i < NQ; i++) begin
      cr_hit[i]  = cr_valid && (cr_qid == QW'(i)) && !q_on[i] && (cr_size >= PW'(2));
      del_hit[i] = del_valid && (del_qid == QW'(i)) && q_on[i];
      t_inc[i]   = (q_tail[i] == q_size[i] - PW'(1)) ? '0 : q_tail[i] + PW'(1);
      was_ne[i]  = q_head[i] != q_tail[i];
      post_ok[i] = post_valid && (post_qid == QW'(i)) && q_on[i] && !del_hit[i]
                   && (t_inc[i] != q_head[i]);
      db_ok[i]   = db_valid && (db_qid == QW'(i)) && q_on[i] && !del_hit[i]
                   && was_ne[i] && (db_head < q_size[i]);
      t_n[i]     = post_ok[i] ? t_inc[i] : q_tail[i];
      h_n[i]     = db_ok[i] ? db_head : q_head[i];
      now_ne[i]  = h_n[i] != t_n[i];
      inc[i]     = q_ien[i] && !del_hit[i] && !was_ne[i] && now_ne[i];
      dec[i]     = q_ien[i] && was_ne[i] && (del_hit[i] || !now_ne[i]);
      if (post_ok[i] && q_ien[i] && now_ne[i])
        set_bits[q_vec[i]] = 1'b1;
      cnt_n = cnt_n + CW'(inc[i]) - CW'(dec[i]);
    end
    drain_req = |dec;
    status_n  = (drain_req && cnt_n == '0) ? '0 : (irq_status | set_bits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_on       <= '0;
      q_ien      <= '0;
      cnt_q      <= '0;
      irq_status <= '0;
      mask_q     <= '0;
      irq_pin    <= 1'b0;
      for (int i = 0; i < NQ; i++) begin
        q_vec[i]  <= '0;
        q_size[i] <= '0;
        q_head[i] <= '0;
        q_tail[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NQ; i++) begin
        if (cr_hit[i]) begin
          q_on[i]   <= 1'b1;
          q_ien[i]  <= cr_ien;
          q_vec[i]  <= cr_vec;
          q_size[i] <= cr_size;
          q_head[i] <= '0;
          q_tail[i] <= '0;
        end else if (del_hit[i]) begin
          q_on[i]   <= 1'b0;
          q_ien[i]  <= 1'b0;
          q_head[i] <= '0;
          q_tail[i] <= '0;
        end else begin
          q_head[i] <= h_n[i];
          q_tail[i] <= t_n[i];
        end
      end
      cnt_q      <= cnt_n;
      irq_status <= status_n;
      if (mask_we) mask_q <= mask_wdata;
      irq_pin    <= |(irq_status & ~mask_q);
    end
  end

  logic [CW-1:0] live_cnt;
  always_comb begin
    live_cnt = '0;
    for (int i = 0; i < NQ; i++)
      live_cnt = live_cnt + CW'(q_on[i] && q_ien[i] && (q_head[i] != q_tail[i]));
  end

  assert_tally_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == live_cnt);

  assert_status_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (irq_status == '0));

  assert_pin_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pin) |-> ($past(cnt_q) == '0 || $past(mask_q) != $past(mask_q, 2)));

  assert_empty_db_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && !post_valid && !del_valid && q_on[db_qid]
     && q_head[db_qid] == q_tail[db_qid]) |=> $stable(cnt_q));

  for (genvar g = 0; g < NQ; g++) begin : g_chk
    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      q_on[g] |-> (q_head[g] < q_size[g] && q_tail[g] < q_size[g]));
  end

endmodule

// File: tb/cq_pin_irq_agg_tb_top.sv
`timescale 1ns/1ps
module cq_pin_irq_agg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cr_valid = 0, cr_ien = 0, del_valid = 0, post_valid = 0, db_valid = 0, mask_we = 0;
  logic [2:0]  cr_qid = 0, del_qid = 0, post_qid = 0, db_qid = 0;
  logic [15:0] cr_size = 0, db_head = 0;
  logic [4:0]  cr_vec = 0;
  logic [31:0] mask_wdata = 0;
  logic        irq_pin;
  logic [31:0] irq_status;
  logic [3:0]  pend_cnt;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] tb_mask = 0;

  string       tag_q[$];
  int          cnt_e[$];
  logic [31:0] st_e[$];
  logic        pin_e[$];

  always #4 clk = ~clk;

  cq_pin_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n),
    .cr_valid(cr_valid), .cr_qid(cr_qid), .cr_size(cr_size), .cr_vec(cr_vec), .cr_ien(cr_ien),
    .del_valid(del_valid), .del_qid(del_qid),
    .post_valid(post_valid), .post_qid(post_qid),
    .db_valid(db_valid), .db_qid(db_qid), .db_head(db_head),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .irq_pin(irq_pin), .irq_status(irq_status), .pend_cnt(pend_cnt)
  );

  always @(negedge clk) begin
    #1;
    while (tag_q.size() > 0) begin
      string t;
      int ec;
      logic [31:0] es;
      logic ep;
      t = tag_q.pop_front(); ec = cnt_e.pop_front(); es = st_e.pop_front(); ep = pin_e.pop_front();
      checks++;
      if (int'(pend_cnt) != ec) begin
        fails++; $display("FAIL %s pend_cnt act=%0d exp=%0d", t, pend_cnt, ec);
      end
      checks++;
      if (irq_status !== es) begin
        fails++; $display("FAIL %s irq_status act=%h exp=%h", t, irq_status, es);
      end
      checks++;
      if (irq_pin !== ep) begin
        fails++; $display("FAIL %s irq_pin act=%0b exp=%0b", t, irq_pin, ep);
      end
    end
  end

  task automatic expect_now(string t, int c, logic [31:0] s);
    tag_q.push_back(t); cnt_e.push_back(c); st_e.push_back(s);
    pin_e.push_back(|(s & ~tb_mask));
  endtask

  task automatic fire(string t, int c, logic [31:0] s);
    @(posedge clk);
    @(negedge clk);
    cr_valid = 0; del_valid = 0; post_valid = 0; db_valid = 0; mask_we = 0;
    @(posedge clk);
    @(negedge clk);
    expect_now(t, c, s);
  endtask

  task automatic do_create(int q, int sz, int v, bit en);
    cr_valid = 1; cr_qid = 3'(q); cr_size = 16'(sz); cr_vec = 5'(v); cr_ien = en;
  endtask
  task automatic do_post(int q);
    post_valid = 1; post_qid = 3'(q);
  endtask
  task automatic do_db(int q, int h);
    db_valid = 1; db_qid = 3'(q); db_head = 16'(h);
  endtask
  task automatic do_del(int q);
    del_valid = 1; del_qid = 3'(q);
  endtask
  task automatic do_mask(logic [31:0] m);
    mask_we = 1; mask_wdata = m; tb_mask = m;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R1 reset state", 0, 32'h0);
    @(negedge clk);
    rst_n = 1;

    do_create(0, 4, 3, 1); fire("R10 create q0", 0, 32'h0);
    do_create(1, 8, 5, 1); fire("R10 create q1", 0, 32'h0);
    do_create(2, 4, 7, 0); fire("R10 create polled q2", 0, 32'h0);
    do_create(3, 4, 3, 1); fire("R10 create q3", 0, 32'h0);

    do_post(0);  fire("R2 first post q0", 1, 32'h08);
    do_post(0);  fire("R2 second post q0 no change", 1, 32'h08);
    do_post(1);  fire("R5 post q1 sets vector 5", 2, 32'h28);
    do_db(0, 2); fire("R3 drain q0 status held", 1, 32'h28);
    do_db(0, 1); fire("R3 doorbell to empty q0 ignored", 1, 32'h28);
    do_db(4, 0); fire("R3 doorbell to absent q4 ignored", 1, 32'h28);
    do_post(2);  fire("R6 polled post no effect", 1, 32'h28);
    do_mask(32'h28); fire("R7 mask hides pin", 1, 32'h28);
    do_mask(32'h20); fire("R7 partial mask", 1, 32'h28);
    do_mask(32'h0);  fire("R7 unmask", 1, 32'h28);
    do_db(1, 1); fire("R5 last drain clears all, R6 polled entries ignored", 0, 32'h0);

    do_post(0);  fire("R8 post q0 tail 3", 1, 32'h08);
    do_post(0);  fire("R8 post q0 wraps tail to 0", 1, 32'h08);
    do_post(0);  fire("R8 post q0 tail 1", 1, 32'h08);
    do_post(0);  fire("R8 post to full q0 ignored", 1, 32'h08);
    do_db(0, 1); fire("R8 drain after full proves ignored post", 0, 32'h0);
    do_post(0);  fire("R2 post q0 tail 2", 1, 32'h08);
    do_db(0, 4); fire("R3 head beyond size ignored", 1, 32'h08);
    do_db(0, 2); fire("R3 drain q0", 0, 32'h0);

    do_post(1);  fire("R9 post q1 tail 2", 1, 32'h20);
    do_post(1); do_db(1, 2); fire("R9 post and ack same queue stays pending", 1, 32'h20);
    do_post(1); do_db(1, 4); fire("R9 post and ack same queue ends empty", 0, 32'h0);

    do_post(3);  fire("R2 post q3", 1, 32'h08);
    do_post(0);  fire("R2 post q0 shared vector", 2, 32'h08);
    do_del(3);   fire("R4 delete pending q3", 1, 32'h08);
    do_post(3);  fire("R4 post to deleted q3 ignored", 1, 32'h08);
    do_del(0);   fire("R4 delete last pending q0", 0, 32'h0);

    do_post(1);  fire("R2 post q1 tail 5", 1, 32'h20);
    do_create(1, 4, 0, 1); fire("R10 create on live q1 ignored", 1, 32'h20);
    do_db(1, 5); fire("R10 q1 kept size 8", 0, 32'h0);
    do_create(3, 4, 9, 1); fire("R10 recreate q3", 0, 32'h0);
    do_post(3);  fire("R10 recreated q3 new vector", 1, 32'h200);
    do_db(3, 1); fire("R3 drain q3", 0, 32'h0);
    do_create(5, 1, 2, 1); fire("R10 create size 1 ignored", 0, 32'h0);
    do_post(5);  fire("R10 post to uncreated q5 ignored", 0, 32'h0);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule